// File: doc/BRIEF.md
# Oversampled 8N1 Serial Receiver with Framing Recovery

This block receives asynchronous serial characters in the 8N1 format: one low start bit, eight data bits sent least significant first, and one high stop bit. An internal divider makes an oversample tick once every `div_i + 1` system clocks. A bit period is eight ticks, so software sets `div_i` to clock / (8 × baud) − 1. The serial input passes through a two-flop synchronizer, and the line reads as idle-high after reset. While hunting, the receiver checks the line on every tick. A low reading marks a start bit. The first data bit is sampled twelve ticks later, which is the middle of that bit. Each later bit is sampled eight ticks after the one before it.

A good stop bit delivers the byte on a valid/ready output, and the receiver starts hunting again at once. A low stop bit means either a framing error or a break. In that case the byte is discarded and a sticky error flag is raised. The receiver then does nothing until the line reads high again.

The output follows valid/ready rules. Once `out_valid_o` rises, it stays high and `out_data_o` stays unchanged until a cycle in which `out_ready_i` is high. The serial line cannot be stalled. For that reason, a byte that completes while the previous one is still waiting replaces it and sets a sticky overrun flag. Both flags are cleared by pulsing `flag_clr_i`.

Top module: `serial_rx_8x`

## Requirements
- R1: After reset, `out_valid_o`, `frame_err_o` and `overrun_o` are 0, and the line is taken as idle-high, so no byte appears while the input stays high.
- R2: One tick occurs every `div_i + 1` clocks, and one bit period is 8 ticks. Bytes are received correctly when `div_i` is 0, 1 or 3.
- R3: A low reading on a tick while hunting starts a frame. Data bits are sampled 12 ticks after that reading and then every 8 ticks. The first bit received becomes bit 0 of `out_data_o`.
- R4: If the stop bit, sampled 8 ticks after the last data bit, reads high, the byte is presented with `out_valid_o` = 1.
- R5: After a good stop bit the receiver hunts again immediately, so frames sent back to back with no idle time are all received.
- R6: If the stop bit reads low, no byte is delivered and `frame_err_o` becomes 1. It stays 1 until a clear.
- R7: After a low stop bit, the receiver starts no frame while the line stays low. Once the line reads high, it hunts normally again.
- R8: A pulse on `flag_clr_i` sets `frame_err_o` and `overrun_o` to 0. A new error in the same cycle as a clear leaves `frame_err_o` at 1.
- R9: While `out_valid_o` = 1 and `out_ready_i` = 0, `out_valid_o` stays 1. `out_data_o` also stays unchanged unless a new byte completes.
- R10: If a good byte completes while an unaccepted byte is held, the new byte replaces the old one and `overrun_o` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Asynchronous serial input line |
| div_i | input | DIV_W | Tick period minus one, in clocks |
| flag_clr_i | input | 1 | Pulse to clear the error and overrun flags |
| out_ready_i | input | 1 | Downstream ready for the received byte |
| out_valid_o | output | 1 | Received byte is held and valid |
| out_data_o | output | DATA_W | Received byte, bit 0 first on the wire |
| frame_err_o | output | 1 | Sticky framing-error or break flag |
| overrun_o | output | 1 | Sticky flag: an unaccepted byte was overwritten |

## Verification
The assertions rely on three things. `div_i` stays constant while a frame is in progress. `flag_clr_i` is a pulse driven synchronously. The serial line holds each level for whole bit periods that match the programmed rate. The stimulus changes `div_i` only while the line is idle. It drives `rx_i` one full bit period per bit, with period 8 × (`div_i` + 1) clocks, and changes every input just after a rising edge. Breaks are modelled as the line held low for several frame lengths before it is released high.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_DATA  = 2'd1,
    ST_STOP  = 2'd2,
    ST_BREAK = 2'd3
  } rx_state_t;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-2:0], line_i};
  end

  assign line_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= div_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_frame_seq.sv
module rx_frame_seq
  import serial_rx_pkg::*;
#(
  parameter int OVS    = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              line_i,
  output logic              push_o,
  output logic              bad_o,
  output logic [DATA_W-1:0] data_o,
  output logic              in_break_o
);
  localparam int FIRST_WAIT = OVS + OVS / 2;
  localparam int CNT_W      = $clog2(FIRST_WAIT + 1);
  localparam int IDX_W      = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FIRST_LOAD = CNT_W'(FIRST_WAIT - 1);
  localparam logic [CNT_W-1:0] BIT_LOAD   = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(DATA_W - 1);

  rx_state_t         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      push_o  <= 1'b0;
      bad_o   <= 1'b0;
    end else begin
      push_o <= 1'b0;
      bad_o  <= 1'b0;
      if (tick_i) begin
        case (state_q)
          ST_HUNT: begin
            if (!line_i) begin
              cnt_q   <= FIRST_LOAD;
              idx_q   <= '0;
              state_q <= ST_DATA;
            end
          end
          ST_DATA: begin
            if (cnt_q == '0) begin
              shift_q <= {line_i, shift_q[DATA_W-1:1]};
              cnt_q   <= BIT_LOAD;
              if (idx_q == LAST_IDX) state_q <= ST_STOP;
              else                   idx_q   <= idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt_q == '0) begin
              if (line_i) begin
                push_o  <= 1'b1;
                state_q <= ST_HUNT;
              end else begin
                bad_o   <= 1'b1;
                state_q <= ST_BREAK;
              end
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          default: begin
            if (line_i) state_q <= ST_HUNT;
          end
        endcase
      end
    end
  end

  assign data_o     = shift_q;
  assign in_break_o = (state_q == ST_BREAK);
endmodule

// File: rtl/rx_out_hold.sv
module rx_out_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_i,
  input  logic              clr_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ovr_o
);
  logic lost;
  assign lost = push_i && valid_o && !ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      ovr_o   <= 1'b0;
    end else begin
      if (push_i) begin
        valid_o <= 1'b1;
        data_o  <= data_i;
      end else if (ready_i) begin
        valid_o <= 1'b0;
      end
      if (lost)       ovr_o <= 1'b1;
      else if (clr_i) ovr_o <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_8x.sv
module serial_rx_8x #(
  parameter int DIV_W  = 12,
  parameter int OVS    = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              flag_clr_i,
  input  logic              out_ready_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              frame_err_o,
  output logic              overrun_o
);
  logic              line_s;
  logic              tick_w;
  logic              push_w;
  logic              bad_w;
  logic              in_break_w;
  logic [DATA_W-1:0] byte_w;

  rx_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(rx_i), .line_o(line_s)
  );

  rx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div_i(div_i), .tick_o(tick_w)
  );

  rx_frame_seq #(.OVS(OVS), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .line_i(line_s),
    .push_o(push_w), .bad_o(bad_w), .data_o(byte_w), .in_break_o(in_break_w)
  );

  rx_out_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .push_i(push_w), .data_i(byte_w),
    .ready_i(out_ready_i), .clr_i(flag_clr_i),
    .valid_o(out_valid_o), .data_o(out_data_o), .ovr_o(overrun_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          frame_err_o <= 1'b0;
    else if (bad_w)      frame_err_o <= 1'b1;
    else if (flag_clr_i) frame_err_o <= 1'b0;
  end
endmodule

// File: rtl/serial_rx_8x_chk.sv
module serial_rx_8x_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              frame_err,
  input logic              overrun,
  input logic              clr,
  input logic              push,
  input logic              bad,
  input logic              in_break
);
  p_hold_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  p_data_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !push |=> $stable(out_data));

  p_overrun_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && push |=> overrun);

  p_err_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> frame_err);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err && !clr |=> frame_err);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad && clr |=> frame_err);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !bad |=> !frame_err);

  p_no_push_in_break_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_break |-> !push);

  p_single_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({push, bad}) <= 1);
endmodule

bind serial_rx_8x serial_rx_8x_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_ready(out_ready_i), .out_valid(out_valid_o),
  .out_data(out_data_o), .frame_err(frame_err_o), .overrun(overrun_o),
  .clr(flag_clr_i), .push(push_w), .bad(bad_w), .in_break(in_break_w)
);

// File: tb/serial_rx_8x_test.sv
module serial_rx_8x_test;
  localparam int DIV_W = 12;
  localparam int LIMIT = 190000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx = 1'b1;
  logic [DIV_W-1:0] div = 12'd1;
  logic             clr = 1'b0;
  logic             ready = 1'b1;
  logic             valid;
  logic [7:0]       data;
  logic             ferr;
  logic             ovr;

  int errors = 0;
  int checks = 0;
  int got = 0;
  int cycles = 0;
  logic [7:0] last = 8'h00;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_rx_8x #(.DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .div_i(div), .flag_clr_i(clr),
    .out_ready_i(ready), .out_valid_o(valid), .out_data_o(data),
    .frame_err_o(ferr), .overrun_o(ovr)
  );

  always @(negedge clk) begin
    if (valid && ready) begin
      got  <= got + 1;
      last <= data;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > LIMIT && !done) begin
      done = 1'b1;
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  function automatic int bit_clks();
    return 8 * (int'(div) + 1);
  endfunction

  task automatic send_frame(input logic [7:0] b, input logic stop);
    logic [9:0] f;
    f = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rx = f[i];
      wait_clk(bit_clks());
    end
    rx = 1'b1;
  endtask

  task automatic pulse_clr();
    clr = 1'b1;
    wait_clk(1);
    clr = 1'b0;
    wait_clk(1);
  endtask

  initial begin
    int n0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(100);
    check("R1 valid after reset", int'(valid), 0);
    check("R1 ferr after reset", int'(ferr), 0);
    check("R1 ovr after reset", int'(ovr), 0);
    check("R1 no byte on idle line", got, 0);

    // R3 R4 R5: all byte values, frames back to back
    for (int b = 0; b < 256; b++) begin
      n0 = got;
      send_frame(8'(b), 1'b1);
      check("R5 byte count back-to-back", got, n0 + 1);
      check("R3 data lsb first", int'(last), b);
    end
    wait_clk(40);

    // R2: other divider settings
    for (int d = 0; d < 3; d++) begin
      div = (d == 0) ? 12'd0 : (d == 1) ? 12'd3 : 12'd2;
      wait_clk(50);
      for (int k = 0; k < 4; k++) begin
        logic [7:0] v;
        v = 8'((k * 73 + d * 29 + 5) & 8'hff);
        n0 = got;
        send_frame(v, 1'b1);
        wait_clk(4);
        check("R2 count at divider", got, n0 + 1);
        check("R2 data at divider", int'(last), int'(v));
      end
    end
    div = 12'd1;
    wait_clk(50);

    // R6 R7: bad stop then break held low
    n0 = got;
    send_frame(8'hA5, 1'b0);
    rx = 1'b0;
    check("R6 ferr set on low stop", int'(ferr), 1);
    wait_clk(30 * bit_clks());
    check("R6 byte dropped", got, n0);
    check("R7 no frame while low", int'(valid), 0);
    check("R6 ferr sticky", int'(ferr), 1);
    rx = 1'b1;
    wait_clk(2 * bit_clks());
    check("R7 still none after release", got, n0);
    send_frame(8'h3C, 1'b1);
    wait_clk(4);
    check("R7 resumes after high", got, n0 + 1);
    check("R7 data after recovery", int'(last), 8'h3C);
    check("R6 ferr held across good byte", int'(ferr), 1);
    pulse_clr();
    check("R8 ferr cleared", int'(ferr), 0);

    // R9 R10: back-pressure and overrun
    ready = 1'b0;
    n0 = got;
    send_frame(8'h5A, 1'b1);
    wait_clk(4 * bit_clks());
    check("R9 valid held", int'(valid), 1);
    check("R9 data held", int'(data), 8'h5A);
    check("R10 no overrun yet", int'(ovr), 0);
    send_frame(8'hC3, 1'b1);
    wait_clk(4);
    check("R10 data replaced", int'(data), 8'hC3);
    check("R10 overrun set", int'(ovr), 1);
    check("R9 valid still held", int'(valid), 1);
    pulse_clr();
    check("R8 overrun cleared", int'(ovr), 0);
    ready = 1'b1;
    wait_clk(3);
    check("R9 accepted once", got, n0 + 1);
    check("R10 accepted data", int'(last), 8'hC3);
    check("R9 valid drops after accept", int'(valid), 0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule